// File: doc/BRIEF.md
# Frame-Transfer Sensor Exposure Sequencer

This block schedules one complete frame for a frame-transfer area image sensor whose photosensitive zone is paired with a masked storage zone. A single start strobe launches the frame. Every phase is timed in cycles of one system clock. The phases run in a fixed order: a cleaning pass that clocks the storage zone, an obturation phase that drains photo-charge, a guard interval, integration, a second guard interval, the image-to-storage transfer and then picture readout.

The block does not generate sensor clock waveforms. It raises start requests to two companion engines: a vertical-transfer phase generator and a line-readout sequencer. Each request carries a line count. The block then waits for the engine's done input. The block drives two sensor controls directly: the antiblooming gate level, and a control that forces all image-zone gates low. The obturation length sets the shortened exposure. Readout can be stretched by an idle count to lower the frame rate, and readout time also serves as integration time for the following frame. A binning bit makes readout run on line pairs.

Top module: `ccd_frame_seq`

## Requirements
- R1: After reset and while idle, busy_o, frame_done_o, gates_low_o, vx_req_o and rd_req_o are 0, and ab_gate_o is 1.
- R2: In the first cycle after an accepted start strobe, rd_req_o is high with rd_clean_o=1, rd_bin_o=0 and rd_lines_o=1044 (1024 useful plus 20 extra lines). Binning does not change these values.
- R3: One cycle after rd_done_i is seen high during cleaning, gates_low_o rises. It stays high for exactly max(obt_len_i,1) consecutive cycles, and ab_gate_o stays high throughout.
- R4: The first cycle with ab_gate_o low comes GUARD_CYC + max(int_len_i,1) + 1 cycles after the last cycle with gates_low_o high. This covers a guard of GUARD_CYC cycles (at least 1 µs) followed by integration.
- R5: vx_req_o pulses exactly GUARD_CYC cycles after ab_gate_o falls, with vx_lines_o=1044. ab_gate_o stays low until the cycle after vx_done_i is seen.
- R6: In the cycle after vx_done_i is seen, ab_gate_o returns high and rd_req_o pulses with rd_clean_o=0. In that pulse, rd_lines_o=1044 and rd_bin_o=0 when the latched binning bit is 0, or rd_lines_o=522 and rd_bin_o=1 when it is 1.
- R7: frame_done_o is a single-cycle pulse that arrives max(idle_len_i,1)+1 cycles after the cycle in which rd_done_i is seen during readout.
- R8: busy_o is high from the cycle after the accepted start until the cycle before frame_done_o, and is low in the frame_done_o cycle.
- R9: Start strobes that arrive while busy_o is high are ignored. obt_len_i, int_len_i, idle_len_i and bin_mode_i are captured at the accepted start, so later changes do not alter the running frame.
- R10: vx_done_i and rd_done_i have no effect outside the phase that waits for them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Frame start strobe |
| obt_len_i | input | CNT_W | Obturation length in cycles (0 acts as 1) |
| int_len_i | input | CNT_W | Integration length in cycles (0 acts as 1) |
| idle_len_i | input | CNT_W | Readout stretch in cycles (0 acts as 1) |
| bin_mode_i | input | 1 | Line-pair binning select |
| vx_req_o | output | 1 | Start request to the vertical-transfer generator |
| vx_lines_o | output | LINE_W | Line shifts requested for the transfer |
| vx_done_i | input | 1 | Transfer generator finished |
| rd_req_o | output | 1 | Start request to the line-readout sequencer |
| rd_clean_o | output | 1 | Request is a cleaning pass |
| rd_bin_o | output | 1 | Readout runs in binning mode |
| rd_lines_o | output | LINE_W | Line count for the readout request |
| rd_done_i | input | 1 | Readout sequencer finished |
| ab_gate_o | output | 1 | Antiblooming gate level |
| gates_low_o | output | 1 | Force all image-zone gates low |
| busy_o | output | 1 | Frame in progress |
| frame_done_o | output | 1 | One-cycle end-of-frame pulse |

## Verification
Each result falls at a fixed cycle count from a visible event. The cleaning request comes one cycle after the start edge. Obturation starts one cycle after the cleaning done. The antiblooming fall comes GUARD_CYC plus the integration length plus one cycle after the last obturation cycle. The transfer request comes GUARD_CYC cycles after that fall, the readout request one cycle after the transfer done, and frame_done the stretch length plus one cycle after the readout done. The bench drives inputs and samples outputs on falling edges. It numbers every cycle from the start edge and records the cycle of each output event, then compares the differences against these sums. It replays the done handshakes with a chosen latency, so each expected value is known before the frame runs.

// File: rtl/ccdseq_pkg.sv
package ccdseq_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_CLEAN,
      ST_OBT,
      ST_GRD1,
      ST_INTEG,
      ST_GRD2,
      ST_XFER,
      ST_READ,
      ST_STRETCH
   } seq_st_e;

   // length value with zero promoted to one, minus one, for a down counter
   function automatic logic [31:0] len_to_load(input logic [31:0] len);
      return (len == 32'd0) ? 32'd0 : len - 32'd1;
   endfunction

endpackage

// File: rtl/ccdseq_timer.sv
module ccdseq_timer #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [CNT_W-1:0] val_i,
   output logic             zero_o
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load_i) begin
         cnt_q <= val_i;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/ccdseq_req.sv
module ccdseq_req #(
   parameter bit HOLD = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic wait_nxt_i,
   output logic req_o
);

   generate
      if (HOLD) begin : g_level
         logic req_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) req_q <= 1'b0;
            else        req_q <= wait_nxt_i;
         end
         assign req_o = req_q;
      end else begin : g_pulse
         logic req_q;
         logic wait_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               req_q  <= 1'b0;
               wait_q <= 1'b0;
            end else begin
               req_q  <= wait_nxt_i && !wait_q;
               wait_q <= wait_nxt_i;
            end
         end
         assign req_o = req_q;

         AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
            req_q |=> !req_q) else $error("request longer than one cycle"); // R6
      end
   endgenerate

endmodule

// File: rtl/ccd_frame_seq.sv
module ccd_frame_seq
   import ccdseq_pkg::*;
#(
   parameter int CNT_W        = 16,
   parameter int USEFUL_LINES = 1024,
   parameter int EXTRA_LINES  = 20,
   parameter int CLK_MHZ      = 100,
   parameter int GUARD_NS     = 1000,
   parameter bit REQ_HOLD     = 1'b0,
   localparam int LINES       = USEFUL_LINES + EXTRA_LINES,
   localparam int PAIRS       = LINES / 2,
   localparam int LINE_W      = $clog2(LINES + 1),
   localparam int GUARD_CYC   = (CLK_MHZ * GUARD_NS + 999) / 1000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [CNT_W-1:0]  obt_len_i,
   input  logic [CNT_W-1:0]  int_len_i,
   input  logic [CNT_W-1:0]  idle_len_i,
   input  logic              bin_mode_i,
   output logic              vx_req_o,
   output logic [LINE_W-1:0] vx_lines_o,
   input  logic              vx_done_i,
   output logic              rd_req_o,
   output logic              rd_clean_o,
   output logic              rd_bin_o,
   output logic [LINE_W-1:0] rd_lines_o,
   input  logic              rd_done_i,
   output logic              ab_gate_o,
   output logic              gates_low_o,
   output logic              busy_o,
   output logic              frame_done_o
);

   generate
      if (LINES % 2 != 0) begin : g_chk_pairs
         $error("line count must be even for pair readout");
      end
      if (GUARD_CYC < 1) begin : g_chk_guard
         $error("guard interval must span at least one cycle");
      end
      if (GUARD_CYC >= (1 << CNT_W) || CNT_W > 31) begin : g_chk_width
         $error("CNT_W too narrow for guard interval");
      end
   endgenerate

   seq_st_e st_q, st_nxt;

   logic [CNT_W-1:0] obt_q, int_q, idle_q;
   logic             bin_q;
   logic             t_load, t_zero;
   logic [CNT_W-1:0] t_val;
   logic             done_q;
   logic             clean_q, rbin_q;
   logic [LINE_W-1:0] rlines_q;
   logic             enter_clean, enter_read;

   // next-state decode
   always_comb begin
      st_nxt = st_q;
      unique case (st_q)
         ST_IDLE:    if (start_i)   st_nxt = ST_CLEAN;
         ST_CLEAN:   if (rd_done_i) st_nxt = ST_OBT;
         ST_OBT:     if (t_zero)    st_nxt = ST_GRD1;
         ST_GRD1:    if (t_zero)    st_nxt = ST_INTEG;
         ST_INTEG:   if (t_zero)    st_nxt = ST_GRD2;
         ST_GRD2:    if (t_zero)    st_nxt = ST_XFER;
         ST_XFER:    if (vx_done_i) st_nxt = ST_READ;
         ST_READ:    if (rd_done_i) st_nxt = ST_STRETCH;
         ST_STRETCH: if (t_zero)    st_nxt = ST_IDLE;
         default:                   st_nxt = ST_IDLE;
      endcase
   end

   // timer load value selected by the phase about to start
   always_comb begin
      t_load = (st_nxt != st_q);
      unique case (st_nxt)
         ST_OBT:            t_val = CNT_W'(len_to_load(32'(obt_q)));
         ST_GRD1, ST_GRD2:  t_val = CNT_W'(GUARD_CYC - 1);
         ST_INTEG:          t_val = CNT_W'(len_to_load(32'(int_q)));
         ST_STRETCH:        t_val = CNT_W'(len_to_load(32'(idle_q)));
         default:           t_val = '0;
      endcase
   end

   ccdseq_timer #(.CNT_W(CNT_W)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (t_load),
      .val_i  (t_val),
      .zero_o (t_zero)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         obt_q  <= '0;
         int_q  <= '0;
         idle_q <= '0;
         bin_q  <= 1'b0;
         done_q <= 1'b0;
      end else begin
         st_q   <= st_nxt;
         done_q <= (st_q == ST_STRETCH) && t_zero;
         if (st_q == ST_IDLE && start_i) begin
            obt_q  <= obt_len_i;
            int_q  <= int_len_i;
            idle_q <= idle_len_i;
            bin_q  <= bin_mode_i;
         end
      end
   end

   // readout request descriptor, captured on entry to a readout phase
   assign enter_clean = (st_nxt == ST_CLEAN) && (st_q != ST_CLEAN);
   assign enter_read  = (st_nxt == ST_READ)  && (st_q != ST_READ);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         clean_q  <= 1'b0;
         rbin_q   <= 1'b0;
         rlines_q <= '0;
      end else if (enter_clean) begin
         clean_q  <= 1'b1;
         rbin_q   <= 1'b0;
         rlines_q <= LINE_W'(LINES);
      end else if (enter_read) begin
         clean_q  <= 1'b0;
         rbin_q   <= bin_q;
         rlines_q <= bin_q ? LINE_W'(PAIRS) : LINE_W'(LINES);
      end
   end

   ccdseq_req #(.HOLD(REQ_HOLD)) u_rd_req (
      .clk        (clk),
      .rst_n      (rst_n),
      .wait_nxt_i ((st_nxt == ST_CLEAN) || (st_nxt == ST_READ)),
      .req_o      (rd_req_o)
   );

   ccdseq_req #(.HOLD(REQ_HOLD)) u_vx_req (
      .clk        (clk),
      .rst_n      (rst_n),
      .wait_nxt_i (st_nxt == ST_XFER),
      .req_o      (vx_req_o)
   );

   assign vx_lines_o   = LINE_W'(LINES);
   assign rd_clean_o   = clean_q;
   assign rd_bin_o     = rbin_q;
   assign rd_lines_o   = rlines_q;
   assign gates_low_o  = (st_q == ST_OBT);
   assign ab_gate_o    = !((st_q == ST_GRD2) || (st_q == ST_XFER));
   assign busy_o       = (st_q != ST_IDLE);
   assign frame_done_o = done_q;

   AST_CLEAN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req_o && rd_clean_o) |-> (rd_lines_o == LINE_W'(LINES) && !rd_bin_o))
      else $error("cleaning pass with wrong line count"); // R2
   AST_OBT_AB_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      gates_low_o |-> ab_gate_o) else $error("obturation with antiblooming low"); // R3
   AST_XFER_AB_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      vx_req_o |-> !ab_gate_o) else $error("transfer with antiblooming high"); // R5
   AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(vx_req_o && rd_req_o)) else $error("both requests at once"); // R6
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done_o |=> !frame_done_o) else $error("frame_done longer than one cycle"); // R7
   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done_o |-> !busy_o) else $error("busy during frame_done"); // R8
   AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && start_i) |=> (busy_o || frame_done_o))
      else $error("start while busy disturbed the frame"); // R9
   AST_XFER_NO_IDLE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && vx_done_i) |=> !vx_req_o) else $error("stray transfer done acted"); // R10

endmodule

// File: tb/ccd_frame_seq_test.sv
module ccd_frame_seq_test;

   localparam int CLK_PERIOD = 10;
   localparam int G          = 100;
   localparam int NLINES     = 1044;
   localparam int NPAIRS     = 522;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_d = 1'b0;
   logic        poke_v = 1'b0;
   logic [15:0] obt_len = '0, int_len = '0, idle_len = '0;
   logic        bin_mode = 1'b0;
   logic        vx_d = 1'b0, rd_d = 1'b0;
   logic        start_w, vx_done_w, rd_done_w;
   logic        vx_req, rd_req, rd_clean, rd_bin, ab_gate, gates_low, busy, frame_done;
   logic [10:0] vx_lines, rd_lines;

   int checks = 0;
   int errors = 0;

   assign start_w   = start_d | poke_v;
   assign vx_done_w = vx_d | poke_v;
   assign rd_done_w = rd_d | poke_v;

   always #(CLK_PERIOD/2) clk = ~clk;

   ccd_frame_seq uut (
      .clk          (clk),
      .rst_n        (rst_n),
      .start_i      (start_w),
      .obt_len_i    (obt_len),
      .int_len_i    (int_len),
      .idle_len_i   (idle_len),
      .bin_mode_i   (bin_mode),
      .vx_req_o     (vx_req),
      .vx_lines_o   (vx_lines),
      .vx_done_i    (vx_done_w),
      .rd_req_o     (rd_req),
      .rd_clean_o   (rd_clean),
      .rd_bin_o     (rd_bin),
      .rd_lines_o   (rd_lines),
      .rd_done_i    (rd_done_w),
      .ab_gate_o    (ab_gate),
      .gates_low_o  (gates_low),
      .busy_o       (busy),
      .frame_done_o (frame_done)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic test_reset();
      @(negedge clk);
      chk(busy == 1'b0,       "R1 busy",       int'(busy), 0);
      chk(frame_done == 1'b0, "R1 frame_done", int'(frame_done), 0);
      chk(gates_low == 1'b0,  "R1 gates_low",  int'(gates_low), 0);
      chk(vx_req == 1'b0 && rd_req == 1'b0, "R1 requests", int'(vx_req) + int'(rd_req), 0);
      chk(ab_gate == 1'b1,    "R1 ab_gate",    int'(ab_gate), 1);
   endtask

   task automatic run_frame(input int obt, input int intg, input int idle,
                            input bit bin, input int lat, input bit poke);
      int k = 1;
      int gl_first = -1, gl_last = -1, gl_cnt = 0, gl_ab_bad = 0;
      int ab_first = -1, ab_cnt = 0;
      int vx_k = -1, vx_n = 0, vxl = 0;
      int rd_n = 0, rd1_k = -1, rd1_c = 0, rd1_l = 0, rd1_b = 0;
      int rd2_k = -1, rd2_c = 0, rd2_l = 0, rd2_b = 0;
      int fd_k = -1, fd_n = 0, busy_bad = 0;
      int vx_wait = -1, rd_wait = -1;
      int oe = (obt == 0) ? 1 : obt;
      int ie = (intg == 0) ? 1 : intg;
      int de = (idle == 0) ? 1 : idle;

      obt_len  = 16'(obt);
      int_len  = 16'(intg);
      idle_len = 16'(idle);
      bin_mode = bin;
      @(negedge clk) start_d = 1'b1;
      @(negedge clk) start_d = 1'b0;
      while (k < 3000) begin
         vx_d = 1'b0; rd_d = 1'b0; poke_v = 1'b0;
         if (gates_low) begin
            if (gl_first < 0) gl_first = k;
            gl_last = k;
            gl_cnt++;
            if (!ab_gate) gl_ab_bad++;
         end
         if (!ab_gate) begin
            if (ab_first < 0) ab_first = k;
            ab_cnt++;
         end
         if (vx_wait > 0) begin vx_wait--; if (vx_wait == 0) vx_d = 1'b1; end
         if (rd_wait > 0) begin rd_wait--; if (rd_wait == 0) rd_d = 1'b1; end
         if (vx_req) begin vx_n++; vx_k = k; vxl = int'(vx_lines); vx_wait = lat; end
         if (rd_req) begin
            rd_n++;
            if (rd_n == 1) begin rd1_k = k; rd1_c = int'(rd_clean); rd1_l = int'(rd_lines); rd1_b = int'(rd_bin); end
            else begin rd2_k = k; rd2_c = int'(rd_clean); rd2_l = int'(rd_lines); rd2_b = int'(rd_bin); end
            rd_wait = lat;
         end
         if (frame_done) begin fd_n++; if (fd_k < 0) fd_k = k; end
         if (fd_k < 0 && !busy) busy_bad++;
         if (frame_done && busy) busy_bad++;
         if (poke && gl_first >= 0 && k == gl_first + 1) begin
            poke_v   = 1'b1;
            obt_len  = 16'd99;
            int_len  = 16'd99;
            idle_len = 16'd99;
            bin_mode = !bin;
         end
         if (fd_k >= 0 && k == fd_k + 1) break;
         @(negedge clk);
         k++;
      end
      vx_d = 1'b0; rd_d = 1'b0; poke_v = 1'b0;

      chk(rd1_k == 1,           "R2 clean request cycle", rd1_k, 1);
      chk(rd1_c == 1,           "R2 clean flag",          rd1_c, 1);
      chk(rd1_l == NLINES,      "R2 clean lines",         rd1_l, NLINES);
      chk(rd1_b == 0,           "R2 clean bin flag",      rd1_b, 0);
      chk(gl_first == lat + 2,  "R3 obturation start",    gl_first, lat + 2);
      chk(gl_cnt == oe,         "R3 obturation length",   gl_cnt, oe);
      chk(gl_last - gl_first + 1 == oe, "R3 obturation contiguous", gl_last - gl_first + 1, oe);
      chk(gl_ab_bad == 0,       "R3 antiblooming during obturation", gl_ab_bad, 0);
      chk(ab_first - gl_last == G + ie + 1, "R4 guard plus integration", ab_first - gl_last, G + ie + 1);
      chk(vx_k - ab_first == G, "R5 guard before transfer", vx_k - ab_first, G);
      chk(ab_cnt == G + lat + 1, "R5 antiblooming low span", ab_cnt, G + lat + 1);
      chk(vxl == NLINES,        "R5 transfer lines",      vxl, NLINES);
      chk(rd2_k == vx_k + lat + 1, "R6 readout request cycle", rd2_k, vx_k + lat + 1);
      chk(rd2_c == 0,           "R6 readout clean flag",  rd2_c, 0);
      chk(rd2_l == (bin ? NPAIRS : NLINES), "R6 readout lines", rd2_l, bin ? NPAIRS : NLINES);
      chk(rd2_b == int'(bin),   "R6 readout bin flag",    rd2_b, int'(bin));
      chk(fd_k - (rd2_k + lat) == de + 1, "R7 frame_done delay", fd_k - (rd2_k + lat), de + 1);
      chk(fd_n == 1,            "R7 frame_done single cycle", fd_n, 1);
      chk(busy_bad == 0,        "R8 busy window",         busy_bad, 0);
      if (poke) begin
         chk(rd_n == 2, "R9 start while busy ignored", rd_n, 2);
         chk(vx_n == 1, "R10 stray done ignored",      vx_n, 1);
      end
   endtask

   task automatic test_plain();
      run_frame(5, 20, 3, 1'b0, 2, 1'b0);
   endtask

   task automatic test_zero_lengths_binned();
      run_frame(0, 0, 0, 1'b1, 1, 1'b0);
   endtask

   task automatic test_disturbed();
      run_frame(7, 4, 9, 1'b1, 3, 1'b1);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog actual %0d expected %0d", 1, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      test_reset();
      rst_n = 1'b1;
      test_reset();
      test_plain();
      test_zero_lengths_binned();
      test_disturbed();
      test_reset();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule